// File: doc/BRIEF.md
# Rate-Adjustable Hardware Time Counter

This block keeps a 64-bit time count in which one tick stands for 8 ns of nominal time. The count does not advance by a fixed one per reference clock. A fractional phase accumulator, driven by a 32-bit rate word, sets how fast it moves. The value 0x80000000 is unity gain. Larger words make the count run faster and smaller words make it run slower, in proportion. The intended trim range is about ±3.2 %, but the arithmetic accepts any rate word. The running count goes out on a port so that neighbouring timing blocks can use it.

Software works the block through simple one-cycle write strobes and a read strobe:

- **Packed command word.** It selects how writes to the count behave. It holds a flag that marks time-stamp correction. It can clear the count. It also sends start and stop strobes to the schedule engine and to the pin-output generator.
- **Count writes.** In absolute mode a write replaces the count. In relative mode the written value is a signed two's-complement delta added to the running count.
- **Read strobe.** It captures the whole 64-bit count in a single cycle, so the two halves of a snapshot always belong to the same instant.

Top module: `phc_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters its reset state. The count is 0, the phase is 0 and the rate word is 0x80000000. Relative mode is off (`add_mode`=0), time-stamp correction is on (`corr_ts`=1), and all strobes and `snap_data` are 0.
- R2: With the rate word at 0x80000000 and no writes, `tick_count` rises by exactly 1 per clock.
- R3: Each clock, the 31-bit phase adds the 32-bit rate word. The two bits above the phase (0, 1 or 2) are added to the count. A rate word of 0xC0000000 gives 3 ticks every 2 clocks from zero phase. A rate word of 0x40000000 gives 1 tick every 2 clocks. A new rate word takes effect from the clock after its write.
- R4: When `add_mode` is 0, a `val_we` write makes `tick_count` equal `val_wdata` after that edge. The increment for that cycle is dropped.
- R5: When `add_mode` is 1, a `val_we` write makes `tick_count` equal the old count plus that cycle's increment plus `val_wdata`, taken as a signed delta. No tick is lost.
- R6: A command write whose bit 31 (valid) is 1 loads `add_mode` from bit 0 and `corr_ts` from bit 2.
- R7: A valid command with bit 3 set clears the count and the phase. This takes priority over a count write in the same cycle. The count then resumes from 0.
- R8: A command write whose bit 31 is 0 is ignored. Mode, flag and count behave as if no write occurred.
- R9: A valid command raises a one-cycle pulse on each of four strobes, one per set bit, in the following cycle: bit 30 drives `sched_start`, bit 29 `sched_stop`, bit 28 `pin_start` and bit 27 `pin_stop`.
- R10: `rd_req` captures the count held before that edge into `snap_data`. The snapshot stays unchanged until the next `rd_req`.
- R11: A count write in the same cycle as a valid command write uses the mode that was in force before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Packed command word |
| val_we | input | 1 | Count write strobe |
| val_wdata | input | 64 | Absolute value or signed delta |
| rate_we | input | 1 | Rate word write strobe |
| rate_wdata | input | 32 | Rate word, unity at 0x80000000 |
| rd_req | input | 1 | Snapshot request |
| tick_count | output | 64 | Running time count in 8 ns ticks |
| snap_data | output | 64 | Last coherent snapshot |
| add_mode | output | 1 | 1 = count writes are relative |
| corr_ts | output | 1 | Time-stamp correction flag |
| sched_start | output | 1 | Schedule start strobe |
| sched_stop | output | 1 | Schedule stop strobe |
| pin_start | output | 1 | Pin-output start strobe |
| pin_stop | output | 1 | Pin-output stop strobe |

## Verification
Two pairs of functions can collide in one cycle, and the bench provokes each collision on purpose.

- **Relative write against the free-running increment.** The bench drives a positive delta, then a negative delta, on a clock where the count also ticks. The count after that edge must equal the old value plus one plus the delta.
- **Command write against a count write.** The bench issues both on the same edge in two cases. In the first, a command that leaves relative mode arrives with a delta. The delta must still be added, and the new mode applies only afterwards. In the second, a clearing command arrives with an absolute write. The count must read zero, not the written value.

// File: rtl/phc_pkg.sv
// Package: shared constants for the time counter.
// Command bit positions are decoded by software, so they are fixed here.
package phc_pkg;
    localparam int unsigned CMD_VALID_BIT  = 31;
    localparam int unsigned CMD_STROBE_LSB = 27;   // bits 27..30 are strobes
    localparam int unsigned CMD_STROBE_N   = 4;
    localparam int unsigned CMD_CLEAR_BIT  = 3;
    localparam int unsigned CMD_CORR_BIT   = 2;
    localparam int unsigned CMD_ADD_BIT    = 0;
    localparam logic [31:0] RATE_UNITY     = 32'h8000_0000;

    typedef enum logic {
        WR_ABSOLUTE = 1'b0,
        WR_RELATIVE = 1'b1
    } wr_mode_e;
endpackage

// File: rtl/phc_cmd_decode.sv
// Module: phc_cmd_decode
// Decodes the packed command word. It keeps the write mode and the
// correction flag. It emits a combinational clear and registered strobes.
// Assumes a command write lasts exactly one cycle of cmd_we.
module phc_cmd_decode
    import phc_pkg::*;
#(
    parameter int unsigned CMD_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_we,
    input  logic [CMD_W-1:0]        cmd_wdata,
    output wr_mode_e                mode,
    output logic                    corr,
    output logic                    clr,
    output logic [CMD_STROBE_N-1:0] strobe
);
    logic accept;
    logic unused_cmd_bits;

    // Purpose: a command counts only when its valid flag is set.
    assign accept = cmd_we && cmd_wdata[CMD_VALID_BIT];
    assign clr    = accept && cmd_wdata[CMD_CLEAR_BIT];
    assign unused_cmd_bits = ^{cmd_wdata[CMD_STROBE_LSB-1:CMD_CLEAR_BIT+1],
                               cmd_wdata[CMD_CORR_BIT-1:CMD_ADD_BIT+1]};

    // Purpose: hold the write mode and the correction flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= WR_ABSOLUTE;
            corr <= 1'b1;
        end else if (accept) begin
            mode <= wr_mode_e'(cmd_wdata[CMD_ADD_BIT]);
            corr <= cmd_wdata[CMD_CORR_BIT];
        end
    end

    // Purpose: one registered one-cycle pulse per strobe bit.
    for (genvar i = 0; i < CMD_STROBE_N; i++) begin : g_strobe
        always_ff @(posedge clk) begin
            if (!rst_n) strobe[i] <= 1'b0;
            else        strobe[i] <= accept && cmd_wdata[CMD_STROBE_LSB + i];
        end
    end
endmodule

// File: rtl/phc_rate_accum.sv
// Module: phc_rate_accum
// Fractional phase accumulator. The rate word is fixed point with unity at
// 2^(RATE_W-1). The phase carries RATE_W-1 fraction bits. The integer part
// of phase+rate (0..2) is the tick increment for this cycle.
module phc_rate_accum
    import phc_pkg::*;
#(
    parameter int unsigned RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic              clr,
    output logic [1:0]        inc
);
    localparam int unsigned FRAC_W = RATE_W - 1;

    logic [RATE_W-1:0] rate_q;
    logic [FRAC_W-1:0] phase_q;
    logic [RATE_W:0]   sum;

    // Purpose: add the rate to the phase and split off the integer ticks.
    assign sum = {2'b00, phase_q} + {1'b0, rate_q};
    assign inc = sum[RATE_W -: 2];

    // Purpose: hold the rate word, which resets to unity.
    always_ff @(posedge clk) begin
        if (!rst_n)       rate_q <= RATE_UNITY[RATE_W-1:0];
        else if (rate_we) rate_q <= rate_wdata;
    end

    // Purpose: advance the phase, or clear it on a clear command.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) phase_q <= '0;
        else               phase_q <= sum[FRAC_W-1:0];
    end
endmodule

// File: rtl/phc_time_count.sv
// Module: phc_time_count
// The 64-bit tick count with absolute and relative writes and a
// single-cycle snapshot register. Priority: clear, then write, then run.
module phc_time_count
    import phc_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  wr_mode_e         mode,
    input  logic             rd_req,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] snap
);
    logic [CNT_W-1:0] inc_ext;
    logic [CNT_W-1:0] next_count;

    assign inc_ext = {{(CNT_W-2){1'b0}}, inc};

    // Purpose: choose the next count from clear, absolute, relative or run.
    always_comb begin
        if (clr)
            next_count = '0;
        else if (wr_en && mode == WR_ABSOLUTE)
            next_count = wr_data;
        else if (wr_en)
            next_count = count + inc_ext + wr_data;
        else
            next_count = count + inc_ext;
    end

    // Purpose: register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= next_count;
    end

    // Purpose: capture the whole count at once on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)      snap <= '0;
        else if (rd_req) snap <= count;
    end
endmodule

// File: rtl/phc_core.sv
// Module: phc_core (top)
// A rate-adjustable time counter with a packed command word, a rate word,
// absolute and relative writes, and a coherent snapshot read.
// Assumes all strobes are synchronous to clk and last one cycle.
module phc_core
    import phc_pkg::*;
#(
    parameter int unsigned CNT_W  = 64,
    parameter int unsigned RATE_W = 32,
    parameter int unsigned CMD_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              val_we,
    input  logic [CNT_W-1:0]  val_wdata,
    input  logic              rate_we,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic              rd_req,
    output logic [CNT_W-1:0]  tick_count,
    output logic [CNT_W-1:0]  snap_data,
    output logic              add_mode,
    output logic              corr_ts,
    output logic              sched_start,
    output logic              sched_stop,
    output logic              pin_start,
    output logic              pin_stop
);
    wr_mode_e                mode;
    logic                    clr;
    logic [1:0]              inc;
    logic [CMD_STROBE_N-1:0] strobe;

    phc_cmd_decode #(.CMD_W(CMD_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .mode(mode), .corr(corr_ts), .clr(clr), .strobe(strobe)
    );

    phc_rate_accum #(.RATE_W(RATE_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_wdata(rate_wdata),
        .clr(clr), .inc(inc)
    );

    phc_time_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .wr_en(val_we),
        .wr_data(val_wdata), .mode(mode), .rd_req(rd_req),
        .count(tick_count), .snap(snap_data)
    );

    assign add_mode    = (mode == WR_RELATIVE);
    assign sched_start = strobe[3];
    assign sched_stop  = strobe[2];
    assign pin_start   = strobe[1];
    assign pin_stop    = strobe[0];
endmodule

// File: rtl/phc_checker.sv
// Module: phc_checker
// Properties for phc_core, attached to it by the bind statement below.
module phc_checker #(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned CMD_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [CMD_W-1:0] cmd_wdata,
    input logic             val_we,
    input logic [CNT_W-1:0] val_wdata,
    input logic             rd_req,
    input logic [CNT_W-1:0] tick_count,
    input logic [CNT_W-1:0] snap_data,
    input logic             add_mode,
    input logic             corr_ts,
    input logic             sched_start
);
    logic clr_cmd;
    assign clr_cmd = cmd_we && cmd_wdata[31] && cmd_wdata[3];

    a_r2_bounded_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!val_we && !cmd_we) |=> (tick_count - $past(tick_count)) <= 2);

    a_r4_abs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (val_we && !add_mode && !clr_cmd) |=> tick_count == $past(val_wdata));

    a_r5_rel_write: assert property (@(posedge clk) disable iff (!rst_n)
        (val_we && add_mode && !clr_cmd)
        |=> (tick_count - $past(tick_count) - $past(val_wdata)) <= 2);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> tick_count == '0);

    a_r8_invalid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !cmd_wdata[31]) |=> ($stable(add_mode) && $stable(corr_ts)));

    a_r9_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_we && cmd_wdata[31]) |=> !sched_start);

    a_r10_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> snap_data == $past(tick_count));
endmodule

bind phc_core phc_checker #(.CNT_W(CNT_W), .CMD_W(CMD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .val_we(val_we), .val_wdata(val_wdata), .rd_req(rd_req),
    .tick_count(tick_count), .snap_data(snap_data), .add_mode(add_mode),
    .corr_ts(corr_ts), .sched_start(sched_start)
);

// File: tb/test_phc_core.sv
`timescale 1ns/1ps
// Directed bench for phc_core. Inputs are driven and outputs sampled
// on the falling edge.
module test_phc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        val_we = 1'b0;
    logic [63:0] val_wdata = '0;
    logic        rate_we = 1'b0;
    logic [31:0] rate_wdata = '0;
    logic        rd_req = 1'b0;
    logic [63:0] tick_count, snap_data;
    logic        add_mode, corr_ts, sched_start, sched_stop, pin_start, pin_stop;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    phc_core i_phc_core (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .val_we(val_we), .val_wdata(val_wdata), .rate_we(rate_we),
        .rate_wdata(rate_wdata), .rd_req(rd_req), .tick_count(tick_count),
        .snap_data(snap_data), .add_mode(add_mode), .corr_ts(corr_ts),
        .sched_start(sched_start), .sched_stop(sched_stop),
        .pin_start(pin_start), .pin_stop(pin_stop)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmd_write(input logic [31:0] w);
        cmd_we = 1'b1; cmd_wdata = w;
        step();
        cmd_we = 1'b0; cmd_wdata = '0;
    endtask

    task automatic val_write(input logic [63:0] v);
        val_we = 1'b1; val_wdata = v;
        step();
        val_we = 1'b0; val_wdata = '0;
    endtask

    task automatic t_reset_state();
        chk("R1 count", tick_count, 64'd0);
        chk("R1 snap", snap_data, 64'd0);
        chk("R1 add_mode", {63'd0, add_mode}, 64'd0);
        chk("R1 corr_ts", {63'd0, corr_ts}, 64'd1);
        chk("R1 strobes", {60'd0, sched_start, sched_stop, pin_start, pin_stop}, 64'd0);
    endtask

    task automatic t_nominal();
        logic [63:0] c0;
        c0 = tick_count;
        repeat (10) step();
        chk("R2 nominal 10 clocks", tick_count, c0 + 64'd10);
    endtask

    task automatic t_set_and_snap();
        logic [63:0] x;
        x = 64'h0000_0001_FFFF_FFFE;
        val_write(x);
        chk("R4 absolute load", tick_count, x);
        rd_req = 1'b1; step(); rd_req = 1'b0;
        chk("R10 snapshot value", snap_data, x);
        repeat (3) step();
        chk("R10 snapshot held", snap_data, x);
        chk("R2 across 32-bit boundary", tick_count, x + 64'd4);
        rd_req = 1'b1; step(); rd_req = 1'b0;
        chk("R10 second snapshot", snap_data, x + 64'd4);
    endtask

    task automatic t_mode_and_add();
        logic [63:0] c0;
        cmd_write(32'h8000_0001);
        chk("R6 add_mode set", {63'd0, add_mode}, 64'd1);
        chk("R6 corr cleared", {63'd0, corr_ts}, 64'd0);
        c0 = tick_count;
        val_write(64'd100);
        chk("R5 add positive with tick", tick_count, c0 + 64'd101);
        c0 = tick_count;
        val_write(-64'sd5);
        chk("R5 add negative with tick", tick_count, c0 + 64'd1 - 64'd5);
    endtask

    task automatic t_invalid_cmd();
        logic [63:0] c0;
        c0 = tick_count;
        cmd_write(32'h4000_000C);
        chk("R8 count not cleared", tick_count, c0 + 64'd1);
        chk("R8 mode kept", {63'd0, add_mode}, 64'd1);
        chk("R8 corr kept", {63'd0, corr_ts}, 64'd0);
        chk("R8 no strobe", {63'd0, sched_start}, 64'd0);
    endtask

    task automatic t_same_cycle();
        logic [63:0] c0;
        c0 = tick_count;
        cmd_we = 1'b1; cmd_wdata = 32'h8000_0004;
        val_we = 1'b1; val_wdata = 64'd10;
        step();
        cmd_we = 1'b0; val_we = 1'b0;
        chk("R11 old mode applied", tick_count, c0 + 64'd11);
        chk("R11 new mode after", {63'd0, add_mode}, 64'd0);
        chk("R6 corr set", {63'd0, corr_ts}, 64'd1);
        val_write(64'h1234);
        chk("R4 absolute after switch", tick_count, 64'h1234);
        cmd_we = 1'b1; cmd_wdata = 32'h8000_0008;
        val_we = 1'b1; val_wdata = 64'h5555;
        step();
        cmd_we = 1'b0; val_we = 1'b0;
        chk("R7 clear beats write", tick_count, 64'd0);
        step();
        chk("R7 resumes from zero", tick_count, 64'd1);
    endtask

    task automatic t_rate(input logic [31:0] rate, input logic [63:0] exp8, input string tag);
        rate_we = 1'b1; rate_wdata = rate; step(); rate_we = 1'b0;
        cmd_write(32'h8000_000C);
        repeat (8) step();
        chk(tag, tick_count, exp8);
    endtask

    task automatic t_strobes();
        cmd_write(32'hC800_0004);
        chk("R9 strobes raised", {60'd0, sched_start, sched_stop, pin_start, pin_stop}, 64'b1001);
        step();
        chk("R9 strobes one cycle", {60'd0, sched_start, sched_stop, pin_start, pin_stop}, 64'd0);
        cmd_write(32'hB000_0004);
        chk("R9 other strobes", {60'd0, sched_start, sched_stop, pin_start, pin_stop}, 64'b0110);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_nominal();
        t_set_and_snap();
        t_mode_and_add();
        t_invalid_cmd();
        t_same_cycle();
        t_rate(32'hC000_0000, 64'd12, "R3 rate 1.5x");
        t_rate(32'h4000_0000, 64'd4, "R3 rate 0.5x");
        t_rate(32'h8000_0000, 64'd8, "R3 rate unity");
        t_strobes();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule